// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Limiter Controller

This block is the attack side of a stereo digital limiter. It runs once per sample strobe. It looks at the post-gain left and right samples and raises a shared attenuation index whenever the louder channel reaches a selectable detection level. One index step equals 0.375 dB. The number of steps added per event depends on how far the peak is above the level, in four overshoot bands. Gain multiplication and release are handled elsewhere: the block only produces attenuation indices for a downstream gain stage.

The shared index is the target. Each channel has its own applied index, which normally moves to the target only at that channel's zero crossing or after a timeout. This keeps gain steps out of the middle of a waveform. Two controls shorten the wait:
- With zero-cross gating off, every change is applied at once.
- With the fast path on, a change is applied at once whenever the peak is at or above full scale.

Samples carry three headroom bits above the nominal data width, so levels up to 8x full scale can be represented.

Top module: `lmt_limiter_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `att_tgt`, `att_l` and `att_r` are all zero.
- R2: While `lim_en` is 0, a strobe never raises `att_tgt`, whatever the sample levels are.
- R3: An event occurs on a strobe when max(|smp_l|, |smp_r|) is at or above the level picked by `thr_sel`. The levels are FS*768/1024, FS*639/1024, FS*513/1024 and FS*385/1024 for codes 0, 1, 2 and 3, where FS = 2^(DATA_W-1). Either channel alone can cause an event.
- R4: With zero-cross gating on, one event adds a number of steps to `att_tgt` set by `step_mode` and the band of the peak. The bands are: at or above the level, >=FS, >=2FS, >=4FS. The step counts are:
  - mode 0: 1, 1, 1, 1
  - mode 1: 2, 2, 2, 2
  - mode 2: 2, 4, 4, 8
  - mode 3: 1, 2, 4, 8
- R5: With `zc_en` = 0, an event adds exactly one step whatever `step_mode` says, and both `att_l` and `att_r` equal the new `att_tgt` after the same strobe.
- R6: With gating on, a channel's applied index takes the target on a strobe where that channel's sample is zero or its sign differs from the previous sample of that channel. After reset the previous sign counts as non-negative. Each channel is gated on its own.
- R7: With `zc_en` = 1, `fast_en` = 1 and the peak >= FS, both applied indices equal the new target after that strobe.
- R8: With `fast_en` = 0, applied indices wait for a crossing or a timeout even when the peak is >= FS.
- R9: A channel whose applied index differs from the target, and that sees no crossing, takes the target on the (TMO_BASE << tmo_sel)-th strobe after the strobe on which it became pending.
- R10: `att_tgt` never decreases. It saturates at 2^ATT_W-1 and never wraps.
- R11: Outputs change only at clock edges where `smp_vld` is 1. `att_l` and `att_r` never exceed `att_tgt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| smp_l | input | DATA_W+3 | Left post-gain sample, two's complement |
| smp_r | input | DATA_W+3 | Right post-gain sample, two's complement |
| lim_en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Detection level select |
| step_mode | input | 2 | Step-count mode |
| zc_en | input | 1 | Zero-cross gating enable |
| fast_en | input | 1 | Apply at once when the peak is >= full scale |
| tmo_sel | input | 2 | Zero-cross timeout select |
| att_tgt | output | ATT_W | Shared target attenuation index |
| att_l | output | ATT_W | Applied left attenuation index |
| att_r | output | ATT_W | Applied right attenuation index |

## Verification
The bench builds the block with DATA_W = 12, ATT_W = 5 and TMO_BASE = 4. With DATA_W = 12, FS is 2048 and every detection level is an exact integer (1536, 1278, 1026, 770), so each boundary can be hit one code below and exactly at the level. A 5-bit index saturates at 31 after a few dozen events, which brings the clamp within reach. The base of 4 makes the timeouts 4 and 8 strobes, so both the last strobe before expiry and the expiry strobe itself can be checked directly.

// File: rtl/lmt_pkg.sv
// Shared types and tables for the limiter controller.
// Assumes callers pass a valid band code; BAND_NONE yields a zero step.
package lmt_pkg;

    // Overshoot band of the louder channel, ordered by level
    typedef enum logic [2:0] {
        BAND_NONE = 3'd0,
        BAND_THR  = 3'd1,
        BAND_FS   = 3'd2,
        BAND_FS6  = 3'd3,
        BAND_FS12 = 3'd4
    } band_e;

    // Detection level as a fraction of full scale, in 1/1024 units
    function automatic int thr_num(input int sel);
        case (sel)
            0:       return 768;
            1:       return 639;
            2:       return 513;
            default: return 385;
        endcase
    endfunction

    // Steps added per event for a given mode and band
    function automatic logic [3:0] step_count(input logic [1:0] mode, input band_e band);
        if (band == BAND_NONE) return 4'd0;
        case (mode)
            2'd0: return 4'd1;
            2'd1: return 4'd2;
            2'd2: begin
                case (band)
                    BAND_THR: return 4'd2;
                    BAND_FS:  return 4'd4;
                    BAND_FS6: return 4'd4;
                    default:  return 4'd8;
                endcase
            end
            default: begin
                case (band)
                    BAND_THR: return 4'd1;
                    BAND_FS:  return 4'd2;
                    BAND_FS6: return 4'd4;
                    default:  return 4'd8;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/lmt_level_detect.sv
// Peak level classifier: takes the louder magnitude of the two channels
// and sorts it into an overshoot band against the selected detection level.
// Assumes samples carry exactly three headroom bits above DATA_W.
module lmt_level_detect #(
    parameter int DATA_W = 24,
    localparam int SMP_W = DATA_W + 3
) (
    input  logic signed [SMP_W-1:0] smp_l,
    input  logic signed [SMP_W-1:0] smp_r,
    input  logic [1:0]              thr_sel,
    output lmt_pkg::band_e          band,
    output logic                    over_fs
);
    import lmt_pkg::*;

    localparam longint FS_LL = longint'(1) << (DATA_W - 1);
    localparam logic [SMP_W-1:0] FS_V   = SMP_W'(FS_LL);
    localparam logic [SMP_W-1:0] FS2_V  = SMP_W'(FS_LL * 2);
    localparam logic [SMP_W-1:0] FS4_V  = SMP_W'(FS_LL * 4);

    logic [SMP_W-1:0] thr_tab [4];
    logic [SMP_W-1:0] mag_l, mag_r, peak, thr;

    // Build the detection level table, one constant per select code
    for (genvar gi = 0; gi < 4; gi++) begin : g_thr
        assign thr_tab[gi] = SMP_W'((FS_LL * longint'(thr_num(gi))) >>> 10);
    end

    // Magnitudes and the louder of the two
    always_comb begin
        mag_l = smp_l[SMP_W-1] ? SMP_W'(~smp_l + 1'b1) : SMP_W'(smp_l);
        mag_r = smp_r[SMP_W-1] ? SMP_W'(~smp_r + 1'b1) : SMP_W'(smp_r);
        peak  = (mag_l >= mag_r) ? mag_l : mag_r;
        thr   = thr_tab[thr_sel];
    end

    // Band classification, highest band first
    always_comb begin
        if (peak >= FS4_V)      band = BAND_FS12;
        else if (peak >= FS2_V) band = BAND_FS6;
        else if (peak >= FS_V)  band = BAND_FS;
        else if (peak >= thr)   band = BAND_THR;
        else                    band = BAND_NONE;
        over_fs = (peak >= FS_V);
    end

endmodule

// File: rtl/lmt_step_sel.sv
// Step-count selector: maps mode and band to the number of 0.375 dB steps.
// With zero-cross gating off, any event is forced to a single step.
module lmt_step_sel (
    input  logic [1:0]     step_mode,
    input  lmt_pkg::band_e band,
    input  logic           zc_en,
    output logic [3:0]     step
);
    import lmt_pkg::*;

    // Table lookup with the single-step override
    always_comb begin
        if (band == BAND_NONE) step = 4'd0;
        else if (!zc_en)       step = 4'd1;
        else                   step = step_count(step_mode, band);
    end

endmodule

// File: rtl/lmt_zc_gate.sv
// Per-channel apply gate: moves the applied index to the target on a zero
// crossing, on timeout while pending, or when the caller forces it.
// Assumes smp_vld is a one-cycle strobe; state only moves on it.
module lmt_zc_gate #(
    parameter int DATA_W   = 24,
    parameter int ATT_W    = 8,
    parameter int TMO_BASE = 128,
    localparam int SMP_W   = DATA_W + 3,
    localparam int TMR_W   = $clog2(TMO_BASE * 8) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [1:0]              tmo_sel,
    input  logic                    apply_now,
    input  logic [ATT_W-1:0]        tgt_cur,
    input  logic [ATT_W-1:0]        tgt_next,
    output logic [ATT_W-1:0]        att
);
    logic             prev_neg;
    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] limit;
    logic             zc, tmo, apply;

    // Crossing, timeout and the combined apply condition
    always_comb begin
        limit = TMR_W'(TMO_BASE) << tmo_sel;
        zc    = (smp == '0) || (smp[SMP_W-1] != prev_neg);
        tmo   = (att != tgt_cur) && (tmr >= limit);
        apply = apply_now || zc || tmo;
    end

    // Sign history, pending timer and applied index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg <= 1'b0;
            tmr      <= '0;
            att      <= '0;
        end else if (smp_vld) begin
            prev_neg <= smp[SMP_W-1];
            if (apply) begin
                att <= tgt_next;
                tmr <= '0;
            end else if (tgt_next != att) begin
                tmr <= tmr + 1'b1;
            end else begin
                tmr <= '0;
            end
        end
    end

endmodule

// File: rtl/lmt_limiter_ctrl.sv
// Stereo limiter attack controller: raises a shared attenuation target on
// level events and hands it to two per-channel zero-cross apply gates.
// Assumes one smp_vld pulse per sample period and samples with 3 headroom bits.
module lmt_limiter_ctrl #(
    parameter int DATA_W   = 24,
    parameter int ATT_W    = 8,
    parameter int TMO_BASE = 128,
    localparam int SMP_W   = DATA_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_l,
    input  logic signed [SMP_W-1:0] smp_r,
    input  logic                    lim_en,
    input  logic [1:0]              thr_sel,
    input  logic [1:0]              step_mode,
    input  logic                    zc_en,
    input  logic                    fast_en,
    input  logic [1:0]              tmo_sel,
    output logic [ATT_W-1:0]        att_tgt,
    output logic [ATT_W-1:0]        att_l,
    output logic [ATT_W-1:0]        att_r
);
    import lmt_pkg::*;

    localparam logic [ATT_W:0] ATT_MAX = {1'b0, {ATT_W{1'b1}}};

    band_e            band;
    logic             over_fs;
    logic [3:0]       step;
    logic             event_hit;
    logic             apply_now;
    logic [ATT_W:0]   sum;
    logic [ATT_W-1:0] tgt_next;
    logic signed [SMP_W-1:0] smp_arr [2];
    logic [ATT_W-1:0] att_arr [2];

    lmt_level_detect #(.DATA_W(DATA_W)) u_detect (
        .smp_l   (smp_l),
        .smp_r   (smp_r),
        .thr_sel (thr_sel),
        .band    (band),
        .over_fs (over_fs)
    );

    lmt_step_sel u_step (
        .step_mode (step_mode),
        .band      (band),
        .zc_en     (zc_en),
        .step      (step)
    );

    // Next target with saturation, and the immediate-apply condition
    always_comb begin
        event_hit = lim_en && (band != BAND_NONE);
        sum       = {1'b0, att_tgt} + (ATT_W+1)'(step);
        if (!event_hit)         tgt_next = att_tgt;
        else if (sum > ATT_MAX) tgt_next = ATT_MAX[ATT_W-1:0];
        else                    tgt_next = sum[ATT_W-1:0];
        apply_now = !zc_en || (fast_en && over_fs);
    end

    // Shared target register, moved once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       att_tgt <= '0;
        else if (smp_vld) att_tgt <= tgt_next;
    end

    assign smp_arr[0] = smp_l;
    assign smp_arr[1] = smp_r;

    // One apply gate per channel
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        lmt_zc_gate #(
            .DATA_W   (DATA_W),
            .ATT_W    (ATT_W),
            .TMO_BASE (TMO_BASE)
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_vld   (smp_vld),
            .smp       (smp_arr[ch]),
            .tmo_sel   (tmo_sel),
            .apply_now (apply_now),
            .tgt_cur   (att_tgt),
            .tgt_next  (tgt_next),
            .att       (att_arr[ch])
        );
    end

    assign att_l = att_arr[0];
    assign att_r = att_arr[1];

endmodule

// File: rtl/lmt_limiter_ctrl_chk.sv
// Property checker for the limiter controller, attached by bind.
// Observes ports only; all properties are disabled during reset.
module lmt_limiter_ctrl_chk #(
    parameter int ATT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             lim_en,
    input logic             zc_en,
    input logic [ATT_W-1:0] att_tgt,
    input logic [ATT_W-1:0] att_l,
    input logic [ATT_W-1:0] att_r
);

    // R10: target never decreases, so it cannot wrap
    assert_tgt_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (att_tgt >= $past(att_tgt)));

    // R11: no output moves on an edge without a strobe
    assert_hold_off_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> ($stable(att_tgt) && $stable(att_l) && $stable(att_r)));

    // R11: applied indices never run ahead of the target
    assert_applied_le_tgt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (att_l <= att_tgt) && (att_r <= att_tgt));

    // R2: a disabled limiter leaves the target alone
    assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !lim_en) |=> $stable(att_tgt));

    // R5: with gating off both channels follow the target at once
    assert_zc_off_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !zc_en) |=> ((att_l == att_tgt) && (att_r == att_tgt)));

    // R5: with gating off an event adds at most one step
    assert_zc_off_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !zc_en) |=> ({1'b0, att_tgt} <= ({1'b0, $past(att_tgt)} + 1'b1)));

    // R4: no event adds more than eight steps
    assert_step_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> ({1'b0, att_tgt} <= ({1'b0, $past(att_tgt)} + 4'd8)));

endmodule

bind lmt_limiter_ctrl lmt_limiter_ctrl_chk #(.ATT_W(ATT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .lim_en  (lim_en),
    .zc_en   (zc_en),
    .att_tgt (att_tgt),
    .att_l   (att_l),
    .att_r   (att_r)
);

// File: tb/lmt_limiter_ctrl_test.sv
// Directed bench for the limiter controller, one task per scenario.
module lmt_limiter_ctrl_test;
    localparam int DATA_W   = 12;
    localparam int ATT_W    = 5;
    localparam int TMO_BASE = 4;
    localparam int SMP_W    = DATA_W + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [SMP_W-1:0] smp_l = '0;
    logic signed [SMP_W-1:0] smp_r = '0;
    logic lim_en = 1'b1;
    logic [1:0] thr_sel = 2'd0;
    logic [1:0] step_mode = 2'd0;
    logic zc_en = 1'b1;
    logic fast_en = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic [ATT_W-1:0] att_tgt, att_l, att_r;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lmt_limiter_ctrl #(.DATA_W(DATA_W), .ATT_W(ATT_W), .TMO_BASE(TMO_BASE)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .lim_en(lim_en), .thr_sel(thr_sel), .step_mode(step_mode), .zc_en(zc_en),
        .fast_en(fast_en), .tmo_sel(tmo_sel), .att_tgt(att_tgt), .att_l(att_l), .att_r(att_r)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One strobe; outputs are valid at the negedge after it
    task automatic drive(input int l, input int r);
        @(negedge clk);
        smp_l = SMP_W'(l);
        smp_r = SMP_W'(r);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic set_mode(input bit zc, input bit fast, input int thr, input int mode, input int tmo);
        zc_en = zc; fast_en = fast;
        thr_sel = 2'(thr); step_mode = 2'(mode); tmo_sel = 2'(tmo);
        lim_en = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 tgt", int'(att_tgt), 0);
        check("R1 att_l", int'(att_l), 0);
        check("R1 att_r", int'(att_r), 0);
    endtask

    task automatic t_levels();
        do_reset();
        set_mode(1'b0, 1'b1, 0, 3, 0);
        drive(1535, 0);  check("R3 below lvl0", int'(att_tgt), 0);
        drive(1536, 0);  check("R3 at lvl0", int'(att_tgt), 1);
        drive(0, -1536); check("R3 right neg", int'(att_tgt), 2);
        thr_sel = 2'd1;
        drive(1277, 0);  check("R3 below lvl1", int'(att_tgt), 2);
        drive(0, 1278);  check("R3 at lvl1", int'(att_tgt), 3);
        thr_sel = 2'd2;
        drive(1025, 0);  check("R3 below lvl2", int'(att_tgt), 3);
        drive(1026, 0);  check("R3 at lvl2", int'(att_tgt), 4);
        thr_sel = 2'd3;
        drive(769, 0);   check("R3 below lvl3", int'(att_tgt), 4);
        drive(770, 0);   check("R3 at lvl3", int'(att_tgt), 5);
    endtask

    task automatic t_zc_off();
        do_reset();
        set_mode(1'b0, 1'b0, 0, 3, 3);
        drive(9000, 100);
        check("R5 single step", int'(att_tgt), 1);
        check("R5 left sync", int'(att_l), 1);
        check("R5 right sync", int'(att_r), 1);
    endtask

    task automatic t_steps();
        int peaks [4] = '{1600, 2048, 4096, 8192};
        int tab [4][4] = '{'{1,1,1,1}, '{2,2,2,2}, '{2,4,4,8}, '{1,2,4,8}};
        for (int m = 0; m < 4; m++) begin
            int acc = 0;
            do_reset();
            set_mode(1'b1, 1'b1, 0, m, 3);
            for (int b = 0; b < 4; b++) begin
                drive(peaks[b], 10);
                acc += tab[m][b];
                check($sformatf("R4 mode%0d band%0d", m, b), int'(att_tgt), acc);
            end
        end
    endtask

    task automatic t_disable_strobe();
        do_reset();
        set_mode(1'b0, 1'b1, 0, 0, 0);
        lim_en = 1'b0;
        drive(9000, 9000);
        check("R2 disabled", int'(att_tgt), 0);
        lim_en = 1'b1;
        @(negedge clk);
        smp_l = SMP_W'(9000);
        repeat (3) @(negedge clk);
        check("R11 no strobe tgt", int'(att_tgt), 0);
        check("R11 no strobe att", int'(att_l), 0);
    endtask

    task automatic t_zero_cross();
        do_reset();
        set_mode(1'b1, 1'b1, 0, 0, 3);
        drive(1600, 100);
        check("R6 tgt", int'(att_tgt), 1);
        check("R6 left waits", int'(att_l), 0);
        check("R6 right waits", int'(att_r), 0);
        drive(100, -100);
        check("R6 right sign change", int'(att_r), 1);
        check("R6 left still waits", int'(att_l), 0);
        drive(0, -100);
        check("R6 left zero sample", int'(att_l), 1);
    endtask

    task automatic t_fast();
        do_reset();
        set_mode(1'b1, 1'b1, 0, 0, 3);
        drive(3000, 100);
        check("R7 left now", int'(att_l), 1);
        check("R7 right now", int'(att_r), 1);
        do_reset();
        set_mode(1'b1, 1'b0, 0, 0, 3);
        drive(3000, 100);
        check("R8 tgt", int'(att_tgt), 1);
        check("R8 left waits", int'(att_l), 0);
        drive(-100, 100);
        check("R8 left at crossing", int'(att_l), 1);
        check("R8 right waits", int'(att_r), 0);
    endtask

    task automatic t_timeout();
        do_reset();
        set_mode(1'b1, 1'b1, 0, 0, 0);
        drive(1600, 10);
        repeat (3) drive(10, 10);
        check("R9 tmo4 before", int'(att_l), 0);
        drive(10, 10);
        check("R9 tmo4 left", int'(att_l), 1);
        check("R9 tmo4 right", int'(att_r), 1);
        tmo_sel = 2'd1;
        drive(1600, 10);
        repeat (7) drive(10, 10);
        check("R9 tmo8 before", int'(att_l), 1);
        drive(10, 10);
        check("R9 tmo8 expiry", int'(att_l), 2);
    endtask

    task automatic t_saturate();
        do_reset();
        set_mode(1'b0, 1'b1, 0, 0, 0);
        repeat (40) drive(1600, 1600);
        check("R10 clamp tgt", int'(att_tgt), 31);
        check("R10 clamp att", int'(att_l), 31);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_levels();
        t_zc_off();
        t_steps();
        t_disable_strobe();
        t_zero_cross();
        t_fast();
        t_timeout();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule